// File: doc/BRIEF.md
# Filtered Input Change-of-State Detector

This block gives software a readable general input port of six pins and watches four of them for level changes. The raw pins and an interrupt-acknowledge level pass through a two-flop synchronizer first. Each watched input then goes to a small filter that takes samples only on cycles where a slow sampling enable is high; in normal use this enable pulses at about 38.4 kHz, so samples are roughly 26 microseconds apart. A new level is taken as real only when two sampling ticks in a row both show it. Each taken change, rising or falling, latches a sticky change bit for that input.

Software selects one of two read views. The port view returns the synchronized pin levels, with the acknowledge level in bit 6 and a constant 1 in bit 7. The change view returns the four sticky change bits in the low nibble and the four filtered levels in the high nibble. Reading the change view clears the change bits. The interrupt request is high while any change bit is set and enabled by its mask bit.

Each filter is a two-state machine. WATCH means the filtered level is stable. CONFIRM means one sample at the other level has been seen. The transitions are as follows. WATCH goes to CONFIRM on a tick whose sample differs from the level. CONFIRM goes back to WATCH on the next tick. On that tick, if the sample still differs, the filter accepts it: the level flips and a change is reported. If the sample matches the level again, the filter rejects it and nothing changes. Without a tick, both states hold.

Top module: `pin_change_detector`

## Requirements
- R1: After reset every filtered level equals RESET_LEVEL (default 1), every change bit is 0 and irq_o is 0.
- R2: With rd_sel_i = 0 (port view), rd_data_o[5:0] shows pins_i and rd_data_o[6] shows iack_i, both delayed by two clock cycles through the synchronizer, and rd_data_o[7] is always 1.
- R3: Filters sample and change state only in cycles where sample_tick_i is 1. Pin changes with no tick leave the levels and the change bits unchanged.
- R4: A level is accepted only after two consecutive ticks both sample the new level. A single differing sample followed by a sample at the old level leaves the level unchanged and reports no change.
- R5: An accepted change in either direction on watched input i (0 to 3) sets change bit i.
- R6: With rd_sel_i = 1 (change view), rd_data_o[3:0] are the change bits and rd_data_o[7:4] are the filtered levels of inputs 3 down to 0.
- R7: A cycle with rd_en_i = 1 and rd_sel_i = 1 returns the current change bits and clears them at the end of that cycle.
- R8: A change accepted in the same cycle as a clearing read leaves its bit set after the read.
- R9: irq_o is the OR over i of change bit i AND irq_en_i[i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 6 | Asynchronous input pins; bits 3:0 are watched |
| iack_i | input | 1 | Interrupt-acknowledge level, shown in port view bit 6 |
| sample_tick_i | input | 1 | One-cycle sampling enable for the filters |
| rd_en_i | input | 1 | Read strobe; clears change bits when rd_sel_i = 1 |
| rd_sel_i | input | 1 | 0 selects the port view, 1 selects the change view |
| irq_en_i | input | 4 | Per-input interrupt enable |
| rd_data_o | output | 8 | Read data for the selected view |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that sample_tick_i is a clean single-cycle enable. They also assume that rd_sel_i is a defined level in every cycle, because the port-view check reads it directly. The stimulus drives all inputs one nanosecond after a rising edge. Each tick lasts exactly one cycle, and a pin change is held for three cycles before the next tick so that the synchronizer has settled. The set-and-clear race is created on purpose by raising the tick and the clearing read in the same cycle.

// File: rtl/pinwatch_pkg.sv
package pinwatch_pkg;
    typedef enum logic {
        ST_WATCH   = 1'b0,
        ST_CONFIRM = 1'b1
    } flt_state_t;

    localparam logic RD_PORT   = 1'b0;
    localparam logic RD_CHANGE = 1'b1;
endpackage

// File: rtl/pinwatch_sync.sv
module pinwatch_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/pinwatch_filter.sv
module pinwatch_filter
    import pinwatch_pkg::*;
#(
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sample_i,
    output logic level_o,
    output logic accept_o
);
    flt_state_t state_q, state_d;
    logic       level_q, level_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WATCH;
            level_q <= RESET_LEVEL;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        level_d  = level_q;
        accept_o = 1'b0;
        if (tick_i) begin
            unique case (state_q)
                ST_WATCH: begin
                    if (sample_i != level_q) state_d = ST_CONFIRM;
                end
                ST_CONFIRM: begin
                    state_d = ST_WATCH;
                    if (sample_i != level_q) begin
                        level_d  = sample_i;
                        accept_o = 1'b1;
                    end
                end
                default: state_d = ST_WATCH;
            endcase
        end
    end

    assign level_o = level_q;

    // R3
    lvl_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_q) |-> $past(tick_i));

    // R4
    lvl_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_q) |-> ($past(state_q) == ST_CONFIRM));

    // R4
    confirm_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_CONFIRM) |-> ($past(sample_i) != level_q));
endmodule

// File: rtl/pin_change_detector.sv
module pin_change_detector
    import pinwatch_pkg::*;
#(
    parameter int   PORT_W      = 6,
    parameter int   WATCH_N     = 4,
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PORT_W-1:0]    pins_i,
    input  logic                 iack_i,
    input  logic                 sample_tick_i,
    input  logic                 rd_en_i,
    input  logic                 rd_sel_i,
    input  logic [WATCH_N-1:0]   irq_en_i,
    output logic [PORT_W+1:0]    rd_data_o,
    output logic                 irq_o
);
    localparam int RD_W   = PORT_W + 2;
    localparam int SYNC_W = PORT_W + 1;

    logic [SYNC_W-1:0]  sync_w;
    logic [WATCH_N-1:0] level_w;
    logic [WATCH_N-1:0] accept_w;
    logic [WATCH_N-1:0] chg_q;
    logic               clear_w;

    pinwatch_sync #(.W(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({iack_i, pins_i}),
        .sync_o  (sync_w)
    );

    for (genvar g = 0; g < WATCH_N; g++) begin : g_flt
        pinwatch_filter #(.RESET_LEVEL(RESET_LEVEL)) u_flt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (sample_tick_i),
            .sample_i (sync_w[g]),
            .level_o  (level_w[g]),
            .accept_o (accept_w[g])
        );
    end

    assign clear_w = rd_en_i && (rd_sel_i == RD_CHANGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chg_q <= '0;
        else        chg_q <= (chg_q & ~{WATCH_N{clear_w}}) | accept_w;
    end

    assign irq_o = |(chg_q & irq_en_i);

    always_comb begin
        rd_data_o = '0;
        if (rd_sel_i == RD_PORT) begin
            rd_data_o[SYNC_W-1:0] = sync_w;
            rd_data_o[RD_W-1]     = 1'b1;
        end else begin
            rd_data_o[2*WATCH_N-1:0] = {level_w, chg_q};
        end
    end

    // R7
    chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(chg_q) & ~chg_q)) |-> $past(clear_w));

    // R8
    chg_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clear_w) && (|$past(accept_w))) |-> ((chg_q & $past(accept_w)) == $past(accept_w)));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clear_w) && !(|$past(accept_w))) |-> !irq_o);

    // R2
    port_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel_i == RD_PORT) |-> rd_data_o[RD_W-1]);
endmodule

// File: tb/pin_change_detector_test.sv
module pin_change_detector_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pins = 6'h3F;
    logic       iack = 1'b0;
    logic       tick = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [3:0] irq_en = 4'h0;
    logic [7:0] rd_data;
    logic       irq;
    logic       probe = 1'b0;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t q[$];

    always #2 clk = ~clk;

    pin_change_detector uut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .iack_i(iack),
        .sample_tick_i(tick), .rd_en_i(rd_en), .rd_sel_i(rd_sel),
        .irq_en_i(irq_en), .rd_data_o(rd_data), .irq_o(irq)
    );

    // Monitor
    always @(negedge clk) begin
        if (probe && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (it.is_irq) begin
                if (irq !== it.exp[0]) begin
                    fails++;
                    $display("FAIL %s: irq actual %b expected %b", it.tag, irq, it.exp[0]);
                end
            end else if (rd_data !== it.exp) begin
                fails++;
                $display("FAIL %s: rd_data actual %h expected %h", it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic expect_rd(input logic sel, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        rd_en = 1'b1; rd_sel = sel; probe = 1'b1;
        q.push_back('{1'b0, exp, tag});
        @(posedge clk); #1;
        rd_en = 1'b0; rd_sel = 1'b0; probe = 1'b0;
    endtask

    task automatic expect_irq(input logic exp, input string tag);
        @(posedge clk); #1;
        probe = 1'b1;
        q.push_back('{1'b1, {7'd0, exp}, tag});
        @(posedge clk); #1;
        probe = 1'b0;
    endtask

    task automatic do_tick();
        @(posedge clk); #1; tick = 1'b1;
        @(posedge clk); #1; tick = 1'b0;
    endtask

    task automatic tick_and_read(input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        tick = 1'b1; rd_en = 1'b1; rd_sel = 1'b1; probe = 1'b1;
        q.push_back('{1'b0, exp, tag});
        @(posedge clk); #1;
        tick = 1'b0; rd_en = 1'b0; rd_sel = 1'b0; probe = 1'b0;
    endtask

    task automatic set_pins(input logic [5:0] v);
        @(posedge clk); #1; pins = v;
        repeat (3) @(posedge clk);
    endtask

    task automatic finish_run();
        repeat (3) @(posedge clk);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        // R1 reset state
        expect_rd(1'b1, 8'hF0, "R1 change view after reset");
        expect_irq(1'b0, "R1 irq after reset");
        // R2 port view
        expect_rd(1'b0, 8'hBF, "R2 port idle");
        set_pins(6'h2A);
        expect_rd(1'b0, 8'hAA, "R2 port pattern");
        @(posedge clk); #1 iack = 1'b1;
        repeat (3) @(posedge clk);
        expect_rd(1'b0, 8'hEA, "R2 port with iack");
        @(posedge clk); #1 iack = 1'b0;
        set_pins(6'h3F);
        // R3 no tick, no change
        expect_rd(1'b1, 8'hF0, "R3 pin swing without tick");
        // R4 glitch rejected
        set_pins(6'h3E);
        do_tick();
        set_pins(6'h3F);
        do_tick();
        do_tick();
        expect_rd(1'b1, 8'hF0, "R4 single sample rejected");
        // R5 falling accepted, R7 clear
        set_pins(6'h3E);
        do_tick();
        do_tick();
        expect_rd(1'b1, 8'hE1, "R5 falling input 0");
        expect_rd(1'b1, 8'hE0, "R7 cleared after read");
        // R4 one tick is not enough
        set_pins(6'h3C);
        do_tick();
        expect_rd(1'b1, 8'hE0, "R4 pending after one tick");
        do_tick();
        expect_rd(1'b1, 8'hC2, "R6 level and change input 1");
        expect_rd(1'b1, 8'hC0, "R7 cleared input 1");
        // R5 rising
        set_pins(6'h3D);
        do_tick();
        do_tick();
        expect_rd(1'b1, 8'hD1, "R5 rising input 0");
        // R9 interrupt masking
        set_pins(6'h3F);
        do_tick();
        do_tick();
        @(posedge clk); #1 irq_en = 4'b0010;
        expect_irq(1'b1, "R9 enabled change raises irq");
        @(posedge clk); #1 irq_en = 4'b0001;
        expect_irq(1'b0, "R9 masked change keeps irq low");
        expect_rd(1'b1, 8'hF2, "R6 change input 1 rising");
        @(posedge clk); #1 irq_en = 4'b1111;
        expect_irq(1'b0, "R9 irq low after clear");
        // R3 long hold without tick
        set_pins(6'h3B);
        repeat (20) @(posedge clk);
        expect_rd(1'b1, 8'hF0, "R3 no tick no change");
        do_tick();
        do_tick();
        expect_irq(1'b1, "R9 irq from input 2");
        expect_rd(1'b1, 8'hB4, "R5 falling input 2");
        // R8 set during clearing read
        set_pins(6'h33);
        do_tick();
        tick_and_read(8'hB0, "R8 read in accept cycle");
        expect_rd(1'b1, 8'h38, "R8 bit kept after race");
        expect_rd(1'b1, 8'h30, "R7 cleared after race");
        finish_run();
    end
endmodule